// File: doc/BRIEF.md
# Invert-Controlled Arithmetic Logic Unit

This block is a purely combinational 32-bit arithmetic logic unit. A 4-bit control word selects one of six working operations: bitwise AND, bitwise OR, addition, subtraction, signed less-than and NOR. It has no separate unit for subtraction, comparison or NOR. Each operand passes through its own optional inverter, and then into a shared bitwise stage and a shared adder. The control word chooses which inversions are applied and which stage's output reaches the result.

A datapath controller places the two operand words and the control word on the inputs. It takes the result and a zero flag from the outputs within the same cycle. The zero flag lets an equality branch run a subtraction and test the outcome.

The adder is a two-level carry-lookahead structure: groups of bits are resolved in parallel, and carries then pass from group to group. The control word is split into two single-bit inversion fields and a 2-bit route field. There are no states and no transitions.

Top module: `alu_core`

## Requirements
- R1: Control word bit 3 inverts operand A and bit 2 inverts operand B before any stage. Bits 1:0 route the result: 00 = bitwise AND, 01 = bitwise OR, 10 = adder sum, 11 = less-than bit. The bit-2 field also drives the adder carry-in.
- R2: Code 0000 yields A AND B, and code 0001 yields A OR B.
- R3: Code 0010 yields A + B modulo 2^32.
- R4: Code 0110 yields A - B modulo 2^32 (two's complement).
- R5: Code 0111 yields 1 in bit 0 when A < B as signed 32-bit numbers, else 0. Bits 31:1 are always 0. The answer stays correct when the subtraction overflows.
- R6: Code 1100 yields NOT A AND NOT B (NOR).
- R7: The zero output is 1 exactly when all 32 result bits are 0.
- R8: Other codes follow the same composition. Code 1101 yields NOT A OR NOT B, and code 0100 yields A AND NOT B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| alu_ctrl | input | 4 | Control word: {invert A, invert B, route[1:0]} |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The zero flag and the arithmetic outputs settle in the same evaluation, so two functions can coincide. A subtraction of equal operands must give a zero result and a raised zero flag together. A less-than whose answer is false must likewise raise zero while the comparison reports 0. The bench provokes both cases with equal operand pairs under code 0110, and with A greater than or equal to B under code 0111. Overflowing cases are included, so that the raw sign and the corrected sign disagree. Each case is judged against an expected result and flag computed in the bench from R4, R5 and R7.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        ROUTE_AND  = 2'b00,
        ROUTE_OR   = 2'b01,
        ROUTE_SUM  = 2'b10,
        ROUTE_LESS = 2'b11
    } alu_route_e;

    typedef struct packed {
        logic       flip_a;
        logic       flip_b;
        alu_route_e route;
    } alu_ctl_t;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    input  logic             flip,
    output logic [WIDTH-1:0] dout
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            assign dout[i] = din[i] ^ flip;
        end
    endgenerate
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] conj,
    output logic [WIDTH-1:0] disj
);
    assign conj = x & y;
    assign disj = x | y;
endmodule

// File: rtl/alu_cla_adder.sv
module alu_cla_adder #(
    parameter int WIDTH = 32,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             carry_msb,
    output logic             carry_out
);
    localparam int NGRP = WIDTH / GROUP;

    logic [NGRP:0]    gcarry;
    logic [WIDTH-1:0] bcarry;

    assign gcarry[0] = cin;

    genvar k;
    generate
        for (k = 0; k < NGRP; k++) begin : g_grp
            logic [GROUP-1:0] gen_b, prp_b, lc;
            logic             grp_gen, grp_prp;

            assign gen_b = x[k*GROUP +: GROUP] & y[k*GROUP +: GROUP];
            assign prp_b = x[k*GROUP +: GROUP] ^ y[k*GROUP +: GROUP];

            always_comb begin
                grp_gen = 1'b0;
                grp_prp = 1'b1;
                for (int i = 0; i < GROUP; i++) begin
                    grp_gen = gen_b[i] | (prp_b[i] & grp_gen);
                    grp_prp = grp_prp & prp_b[i];
                end
            end

            assign gcarry[k+1] = grp_gen | (grp_prp & gcarry[k]);

            always_comb begin
                lc[0] = gcarry[k];
                for (int i = 1; i < GROUP; i++) begin
                    lc[i] = gen_b[i-1] | (prp_b[i-1] & lc[i-1]);
                end
            end

            assign bcarry[k*GROUP +: GROUP] = lc;
            assign sum[k*GROUP +: GROUP]    = prp_b ^ lc;
        end
    endgenerate

    assign carry_msb = bcarry[WIDTH-1];
    assign carry_out = gcarry[NGRP];
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    output logic             all_clear
);
    assign all_clear = ~(|value);
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int WIDTH = 32,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       alu_ctrl,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    import alu_pkg::*;

    alu_ctl_t         ctl;
    logic [WIDTH-1:0] a_eff, b_eff, conj, disj, sum;
    logic             c_msb, c_out, ovf, less_bit;

    assign ctl = alu_ctl_t'(alu_ctrl);

    alu_operand_prep #(.WIDTH(WIDTH)) u_prep_a (.din(op_a), .flip(ctl.flip_a), .dout(a_eff));
    alu_operand_prep #(.WIDTH(WIDTH)) u_prep_b (.din(op_b), .flip(ctl.flip_b), .dout(b_eff));

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (.x(a_eff), .y(b_eff), .conj(conj), .disj(disj));

    alu_cla_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_adder (
        .x(a_eff), .y(b_eff), .cin(ctl.flip_b),
        .sum(sum), .carry_msb(c_msb), .carry_out(c_out)
    );

    // Signed overflow corrects the raw sign for the less-than bit.
    assign ovf      = c_msb ^ c_out;
    assign less_bit = sum[WIDTH-1] ^ ovf;

    always_comb begin
        unique case (ctl.route)
            ROUTE_AND:  result = conj;
            ROUTE_OR:   result = disj;
            ROUTE_SUM:  result = sum;
            ROUTE_LESS: result = {{(WIDTH-1){1'b0}}, less_bit};
        endcase
    end

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (.value(result), .all_clear(zero));

    always_comb begin
        if (alu_ctrl == 4'b0010)
            assert_add_R3: assert (result == op_a + op_b);
        if (alu_ctrl == 4'b0110)
            assert_sub_R4: assert (result == op_a - op_b);
        if (alu_ctrl == 4'b0111)
            assert_slt_R5: assert (result == {{(WIDTH-1){1'b0}}, ($signed(op_a) < $signed(op_b))});
        if (alu_ctrl == 4'b1100)
            assert_nor_R6: assert (result == ~(op_a | op_b));
        assert_zero_R7: assert (zero == (result == '0));
    end
endmodule

// File: tb/alu_core_bench.sv
module alu_core_bench;
    logic        clk = 1'b0;
    logic [31:0] op_a, op_b;
    logic [3:0]  alu_ctrl;
    logic [31:0] result;
    logic        zero;
    int          n_checks = 0;
    int          n_errors = 0;

    always #10 clk = ~clk;

    alu_core u_alu_core (.op_a(op_a), .op_b(op_b), .alu_ctrl(alu_ctrl), .result(result), .zero(zero));

    task automatic apply_and_check(input string tag, input logic [3:0] code,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [31:0] exp_r);
        @(negedge clk);
        op_a = a; op_b = b; alu_ctrl = code;
        @(posedge clk);
        #3;
        n_checks++;
        if (result !== exp_r) begin
            n_errors++;
            $display("FAIL %s result code=%b actual=%h expected=%h", tag, code, result, exp_r);
        end
        n_checks++;
        if (zero !== (exp_r == 32'h0)) begin
            n_errors++;
            $display("FAIL R7 zero (%s) code=%b actual=%b expected=%b", tag, code, zero, exp_r == 32'h0);
        end
    endtask

    task automatic t_reset;
        op_a = '0; op_b = '0; alu_ctrl = '0;
        repeat (2) @(posedge clk);
        apply_and_check("R2 reset", 4'b0000, 32'h0, 32'h0, 32'h0);
    endtask

    task automatic t_bitwise;
        apply_and_check("R2 and", 4'b0000, 32'hF0F0_1234, 32'hFF00_00FF, 32'hF000_0034);
        apply_and_check("R2 or",  4'b0001, 32'hF0F0_1234, 32'h0F00_00C0, 32'hFFF0_12F4);
        apply_and_check("R1 and-route", 4'b0000, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0);
    endtask

    task automatic t_add;
        apply_and_check("R3 add", 4'b0010, 32'd1000, 32'd2345, 32'd3345);
        apply_and_check("R3 carry chain", 4'b0010, 32'h0000_FFFF, 32'h0000_0001, 32'h0001_0000);
        apply_and_check("R3 wrap", 4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0);
        apply_and_check("R3 ovf", 4'b0010, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000);
    endtask

    task automatic t_sub;
        apply_and_check("R4 sub", 4'b0110, 32'd50, 32'd8, 32'd42);
        apply_and_check("R4 neg", 4'b0110, 32'd8, 32'd50, 32'hFFFF_FFD6);
        apply_and_check("R4 equal+R7", 4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0);
        apply_and_check("R4 min", 4'b0110, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF);
    endtask

    task automatic t_slt;
        apply_and_check("R5 lt", 4'b0111, 32'd3, 32'd7, 32'h1);
        apply_and_check("R5 gt", 4'b0111, 32'd7, 32'd3, 32'h0);
        apply_and_check("R5 eq", 4'b0111, 32'd9, 32'd9, 32'h0);
        apply_and_check("R5 neg", 4'b0111, 32'hFFFF_FFFF, 32'h0, 32'h1);
        apply_and_check("R5 ovf lt", 4'b0111, 32'h8000_0000, 32'h1, 32'h1);
        apply_and_check("R5 ovf gt", 4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    endtask

    task automatic t_nor;
        apply_and_check("R6 nor", 4'b1100, 32'h0F0F_0000, 32'h00F0_000F, 32'hF000_FFF0);
        apply_and_check("R6 nor ones", 4'b1100, 32'hFFFF_0000, 32'h0000_FFFF, 32'h0);
    endtask

    task automatic t_compose;
        apply_and_check("R8 nand", 4'b1101, 32'hFF00_FF00, 32'hF0F0_F0F0, 32'h0FFF_0FFF);
        apply_and_check("R8 andnot", 4'b0100, 32'hFF00_FF00, 32'hF0F0_F0F0, 32'h0F00_0F00);
    endtask

    initial begin
        #4_000_000;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset;
        t_bitwise;
        t_add;
        t_sub;
        t_slt;
        t_nor;
        t_compose;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule